// File: doc/BRIEF.md
# Instruction Cache Touch Prefetch Controller

This block executes the instruction-cache block-touch hint of a small embedded processor. It takes one 32-bit instruction word with the two general-register values the pipeline has read for it, and recognises the touch encoding. It adds the index register to an optional base register to form the effective address. It then decides whether the addressed cache line should be fetched ahead of use. A program issues the hint some time before it branches to a code region, so that the later fetch hits in the instruction cache.

The block never raises an exception. It issues a line fill only when the tag lookup misses and the address is cachable. A tag hit, a non-cachable region, a translation miss or a read-permission refusal each turns the operation into a silent no-op. When data translation is off, cachability comes from a 32-bit region mask in which each bit covers one 128 MB region. When translation is on, it comes from the TLB response. Every decoded operation presents its effective address on a debug compare strobe, as a load would. Every decoded operation ends with exactly one done pulse.

Top module: `icache_touch_ctrl`

## Requirements
- R1: An operation is accepted only when `op_valid` is high, `op_ready` is high, `instr[31:26]` equals 31 and `instr[10:1]` equals 262. Any other word is ignored: no strobe, no fill and no done.
- R2: The effective address is `reg_b` plus a base, modulo 2^32. The base is zero when the base-register field `instr[20:16]` is 0, and is `reg_a` otherwise.
- R3: On a tag miss to a cachable address, `fill_req` rises with `fill_addr` equal to the effective address with bits 4:0 cleared. The request and its address hold until the cycle in which `fill_ack` is sampled high.
- R4: When `tag_hit` is high during the lookup cycle, no fill is requested.
- R5: With `dtrans_en` low at accept, the address is cachable when bit `ea[31:27]` of `region_cache_mask` is 1 (bit 0 covers the lowest 128 MB). The TLB inputs are then ignored.
- R6: With `dtrans_en` high at accept, `region_cache_mask` is ignored. A high `tlb_miss` makes the operation a no-op, and otherwise cachability is `tlb_cachable`.
- R7: With `dtrans_en` high, a high `tlb_read_deny` makes the operation a no-op. No fault of any kind is signalled.
- R8: Each accepted operation pulses `dac_strobe` for exactly one cycle, in the cycle after accept, with `dac_addr` equal to the full effective address.
- R9: Each accepted operation yields exactly one one-cycle `done` pulse. A no-op gives it two cycles after the accept edge. A fill gives it one cycle after the edge at which `fill_ack` is taken.
- R10: `op_ready` is low from the accept edge until the cycle after `done`. Operations offered while it is low are ignored.
- R11: The record bit `instr[0]` has no effect on decode, address or outcome.
- R12: After reset, `op_ready` is high and `fill_req`, `done` and `dac_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction word offered |
| op_ready | output | 1 | Controller idle and able to accept |
| instr | input | 32 | Instruction word |
| reg_a | input | 32 | Base register value |
| reg_b | input | 32 | Index register value |
| dtrans_en | input | 1 | Data-side translation enable, captured at accept |
| region_cache_mask | input | 32 | Per-128 MB cachability bits for untranslated accesses |
| lookup_addr | output | 32 | Line address presented to tag and TLB lookup |
| tag_hit | input | 1 | Instruction cache tag hit for `lookup_addr` |
| tlb_miss | input | 1 | TLB has no entry for `lookup_addr` |
| tlb_cachable | input | 1 | TLB entry marks page cachable |
| tlb_read_deny | input | 1 | TLB entry refuses a load |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_ack | input | 1 | Fill request taken |
| done | output | 1 | One-cycle completion pulse |
| dac_strobe | output | 1 | Debug load-address compare strobe |
| dac_addr | output | 32 | Effective address for debug compare |

## Verification
The bound checker watches the port-level protocol on every cycle. It checks that a fill request holds with a stable, line-aligned address until acknowledged, and that a fill starts only after a strobe. It also checks that done and the debug strobe are single-cycle pulses and that nothing is active while the controller is idle. The cachability choice between region mask and TLB, the base-register zero rule, address wrap and decode rejection depend on data values. Those are shown only by the bench's scenarios. In them, a scoreboard predicts the fill decision and addresses for each operation and measures done latency.

// File: rtl/icache_touch_pkg.sv
// Shared constants and types for the instruction cache touch controller.
// Assumes big-endian instruction bit numbering mapped onto [31:0].
package icache_touch_pkg;
    localparam int          INSN_W     = 32;
    localparam logic [5:0]  PRIMARY_OP = 6'd31;
    localparam logic [9:0]  EXT_OP     = 10'd262;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_DONE
    } touch_state_e;
endpackage

// File: rtl/touch_decode.sv
// Recognises the touch encoding and forms the effective address.
// Purely combinational; assumes register values are already read.
module touch_decode
    import icache_touch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [INSN_W-1:0] instr,
    input  logic [ADDR_W-1:0] reg_a,
    input  logic [ADDR_W-1:0] reg_b,
    output logic              is_touch,
    output logic [ADDR_W-1:0] ea
);
    logic [4:0]        base_sel;
    logic [ADDR_W-1:0] base_val;
    logic              unused_fields;

    // Target, index-name and record fields do not steer this block.
    assign unused_fields = ^{instr[25:21], instr[15:11], instr[0]};
    assign base_sel      = instr[20:16];

    // Match primary and extended opcode fields.
    always_comb begin
        is_touch = (instr[31:26] == PRIMARY_OP) && (instr[10:1] == EXT_OP);
    end

    // Base is zero for register field 0, else the register value.
    always_comb begin
        base_val = (base_sel == 5'd0) ? '0 : reg_a;
        ea       = base_val + reg_b;
    end
endmodule

// File: rtl/touch_policy.sv
// Decides whether a touch needs a line fill. Uses the region mask when
// translation is off, the TLB attributes when it is on. Combinational.
module touch_policy #(
    parameter int REGION_BITS = 5
) (
    input  logic                      xlate_on,
    input  logic [REGION_BITS-1:0]    region_idx,
    input  logic [2**REGION_BITS-1:0] region_mask,
    input  logic                      tag_hit,
    input  logic                      tlb_miss,
    input  logic                      tlb_cachable,
    input  logic                      tlb_read_deny,
    output logic                      need_fill
);
    logic cachable;
    logic xlate_ok;

    // Select the cachability source.
    always_comb begin
        if (xlate_on) begin
            cachable = tlb_cachable;
            xlate_ok = !tlb_miss && !tlb_read_deny;
        end else begin
            cachable = region_mask[region_idx];
            xlate_ok = 1'b1;
        end
    end

    // A fill is needed only for a permitted, cachable miss.
    always_comb begin
        need_fill = xlate_ok && cachable && !tag_hit;
    end
endmodule

// File: rtl/icache_touch_ctrl.sv
// Top of the touch controller: accepts one operation at a time, performs
// a one-cycle lookup, optionally holds a fill request until acknowledged,
// then pulses done. Assumes lookup responses are valid in the lookup cycle.
module icache_touch_ctrl
    import icache_touch_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int REGION_BITS = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_valid,
    output logic                      op_ready,
    input  logic [INSN_W-1:0]         instr,
    input  logic [ADDR_W-1:0]         reg_a,
    input  logic [ADDR_W-1:0]         reg_b,
    input  logic                      dtrans_en,
    input  logic [2**REGION_BITS-1:0] region_cache_mask,
    output logic [ADDR_W-1:0]         lookup_addr,
    input  logic                      tag_hit,
    input  logic                      tlb_miss,
    input  logic                      tlb_cachable,
    input  logic                      tlb_read_deny,
    output logic                      fill_req,
    output logic [ADDR_W-1:0]         fill_addr,
    input  logic                      fill_ack,
    output logic                      done,
    output logic                      dac_strobe,
    output logic [ADDR_W-1:0]         dac_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    touch_state_e      state;
    logic              is_touch;
    logic [ADDR_W-1:0] ea_now;
    logic [ADDR_W-1:0] ea_q;
    logic              xlate_q;
    logic              need_fill;
    logic [ADDR_W-1:0] line_addr;

    touch_decode #(.ADDR_W(ADDR_W)) u_decode (
        .instr    (instr),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .is_touch (is_touch),
        .ea       (ea_now)
    );

    touch_policy #(.REGION_BITS(REGION_BITS)) u_policy (
        .xlate_on      (xlate_q),
        .region_idx    (ea_q[ADDR_W-1 -: REGION_BITS]),
        .region_mask   (region_cache_mask),
        .tag_hit       (tag_hit),
        .tlb_miss      (tlb_miss),
        .tlb_cachable  (tlb_cachable),
        .tlb_read_deny (tlb_read_deny),
        .need_fill     (need_fill)
    );

    // Clear the line offset, or pass through for byte-sized lines.
    generate
        if (OFF_W > 0) begin : g_align
            assign line_addr = {ea_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end else begin : g_noalign
            assign line_addr = ea_q;
        end
    endgenerate

    // Sequence accept, lookup, optional fill and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ea_q    <= '0;
            xlate_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (op_valid && is_touch) begin
                        state   <= ST_LOOKUP;
                        ea_q    <= ea_now;
                        xlate_q <= dtrans_en;
                    end
                end
                ST_LOOKUP: state <= need_fill ? ST_FILL : ST_DONE;
                ST_FILL:   if (fill_ack) state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Drive outputs from the current state.
    always_comb begin
        op_ready    = (state == ST_IDLE);
        dac_strobe  = (state == ST_LOOKUP);
        fill_req    = (state == ST_FILL);
        done        = (state == ST_DONE);
        lookup_addr = line_addr;
        fill_addr   = line_addr;
        dac_addr    = ea_q;
    end
endmodule

// File: rtl/icache_touch_ctrl_chk.sv
// Port-level protocol checker for the touch controller, bound to the top.
module icache_touch_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_ready,
    input logic              fill_req,
    input logic              fill_ack,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              done,
    input logic              dac_strobe
);
    localparam int OFF_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_ack |=> fill_req && $stable(fill_addr));

    // R3
    fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (fill_addr[OFF_W-1:0] == '0) || (LINE_BYTES == 1));

    // R3
    fill_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(dac_strobe));

    // R8
    dac_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |=> !dac_strobe);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && op_ready);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !fill_req && !done && !dac_strobe);
endmodule

bind icache_touch_ctrl icache_touch_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_ready   (op_ready),
    .fill_req   (fill_req),
    .fill_ack   (fill_ack),
    .fill_addr  (fill_addr),
    .done       (done),
    .dac_strobe (dac_strobe)
);

// File: tb/icache_touch_ctrl_test.sv
`timescale 1ns/1ps
module icache_touch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [31:0] instr = '0;
    logic [31:0] reg_a = '0;
    logic [31:0] reg_b = '0;
    logic        dtrans_en = 1'b0;
    logic [31:0] region_cache_mask = '1;
    logic [31:0] lookup_addr;
    logic        tag_hit = 1'b0;
    logic        tlb_miss = 1'b0;
    logic        tlb_cachable = 1'b0;
    logic        tlb_read_deny = 1'b0;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_ack = 1'b0;
    logic        done;
    logic        dac_strobe;
    logic [31:0] dac_addr;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int dac_cnt = 0;

    typedef struct {
        logic        fill;
        logic [31:0] ea;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    logic        seen_fill = 1'b0;
    logic        seen_dac = 1'b0;
    logic [31:0] fill_seen = '0;
    logic [31:0] dac_seen = '0;

    always #10 clk = ~clk;

    icache_touch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .instr(instr), .reg_a(reg_a), .reg_b(reg_b), .dtrans_en(dtrans_en),
        .region_cache_mask(region_cache_mask), .lookup_addr(lookup_addr),
        .tag_hit(tag_hit), .tlb_miss(tlb_miss), .tlb_cachable(tlb_cachable),
        .tlb_read_deny(tlb_read_deny), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_ack(fill_ack), .done(done), .dac_strobe(dac_strobe), .dac_addr(dac_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] ra, input logic rc);
        return {6'd31, 5'd2, ra, 5'd7, 10'd262, rc};
    endfunction

    // Monitor: collect outputs and score each operation at done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_strobe) begin
                dac_cnt++;
                seen_dac = 1'b1;
                dac_seen = dac_addr;
            end
            if (fill_req) begin
                if (seen_fill && fill_addr != fill_seen)
                    chk(0, "R3 fill address moved", fill_addr, fill_seen);
                if (!seen_fill) fill_seen = fill_addr;
                seen_fill = 1'b1;
            end
            if (done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(seen_fill == e.fill, {e.req, " fill decision"}, {31'd0, seen_fill}, {31'd0, e.fill});
                    if (e.fill)
                        chk(fill_seen == {e.ea[31:5], 5'd0}, {e.req, " R3 fill address"}, fill_seen, {e.ea[31:5], 5'd0});
                    chk(seen_dac && dac_seen == e.ea, {e.req, " R8 debug address"}, dac_seen, e.ea);
                end
                seen_fill = 1'b0;
                seen_dac = 1'b0;
            end
        end
    end

    // Driver: offer one decoded operation, answer its fill, time its done.
    task automatic run_op(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b,
                          input logic exp_fill, input logic [31:0] exp_ea, input string req,
                          input int ack_delay, input bit poke);
        int cyc;
        int ack_cyc;
        int waited;
        bit fin;
        exp_t e;
        @(negedge clk);
        chk(op_ready == 1'b1, "R10 ready before op", {31'd0, op_ready}, 32'd1);
        instr = iw; reg_a = a; reg_b = b; op_valid = 1'b1;
        e.fill = exp_fill; e.ea = exp_ea; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        op_valid = 1'b0;
        cyc = 1; ack_cyc = -1; waited = 0; fin = 0;
        while (!fin && cyc < 100) begin
            if (done) begin
                fin = 1;
                if (exp_fill) chk(cyc == ack_cyc + 1, "R9 done after ack", cyc, ack_cyc + 1);
                else          chk(cyc == 2, "R9 no-op latency", cyc, 2);
            end else begin
                if (fill_req && !fill_ack) begin
                    if (poke && waited == 1) begin
                        chk(op_ready == 1'b0, "R10 busy during fill", {31'd0, op_ready}, 32'd0);
                        instr = mk(5'd1, 1'b0); reg_a = 32'h3000_0000; reg_b = 32'h0;
                        op_valid = 1'b1;
                    end
                    if (waited >= ack_delay) begin
                        fill_ack = 1'b1;
                        ack_cyc = cyc;
                    end else begin
                        waited++;
                    end
                end
                @(negedge clk);
                op_valid = 1'b0;
                cyc++;
            end
        end
        if (!fin) chk(0, "R9 done missing", 32'd0, 32'd1);
        fill_ack = 1'b0;
    endtask

    // Offer a word that must be rejected and confirm nothing happens.
    task automatic reject_op(input logic [31:0] iw, input string req);
        int d0;
        int s0;
        @(negedge clk);
        d0 = done_cnt; s0 = dac_cnt;
        instr = iw; reg_a = 32'h1000_0000; reg_b = 32'h40; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(done_cnt == d0 && dac_cnt == s0, req, done_cnt - d0 + dac_cnt - s0, 32'd0);
        chk(op_ready == 1'b1, {req, " ready"}, {31'd0, op_ready}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(op_ready == 1'b1, "R12 op_ready", {31'd0, op_ready}, 32'd1);
        chk(!fill_req && !done && !dac_strobe, "R12 outputs idle",
            {29'd0, fill_req, done, dac_strobe}, 32'd0);
        rst_n = 1'b1;

        // R2 R3: base register plus index, cachable miss, delayed ack
        run_op(mk(5'd3, 1'b0), 32'h1000_0000, 32'h47, 1'b1, 32'h1000_0047, "R3", 3, 1'b0);
        // R2: base field zero ignores reg_a
        run_op(mk(5'd0, 1'b0), 32'hDEAD_0000, 32'h2000_0123, 1'b1, 32'h2000_0123, "R2", 0, 1'b0);
        // R2: address wraps modulo 2^32
        run_op(mk(5'd4, 1'b0), 32'hFFFF_FFF0, 32'h20, 1'b1, 32'h0000_0010, "R2 wrap", 1, 1'b0);
        // R4: tag hit gives no fill
        tag_hit = 1'b1;
        run_op(mk(5'd3, 1'b0), 32'h1000_0000, 32'h47, 1'b0, 32'h1000_0047, "R4", 0, 1'b0);
        tag_hit = 1'b0;
        // R5: region 1 marked non-cachable
        region_cache_mask = ~32'h2;
        tlb_cachable = 1'b1;
        run_op(mk(5'd5, 1'b0), 32'h0800_0000, 32'h10, 1'b0, 32'h0800_0010, "R5 region1", 0, 1'b0);
        // R5: only top region cachable; TLB inputs ignored
        region_cache_mask = 32'h8000_0000;
        tlb_cachable = 1'b0; tlb_miss = 1'b1;
        run_op(mk(5'd5, 1'b0), 32'hF800_0000, 32'h3C, 1'b1, 32'hF800_003C, "R5 region31", 2, 1'b0);
        tlb_miss = 1'b0;
        // R6: translation on, mask ignored, TLB says cachable
        dtrans_en = 1'b1; region_cache_mask = '0; tlb_cachable = 1'b1;
        run_op(mk(5'd6, 1'b0), 32'h4000_0000, 32'h81, 1'b1, 32'h4000_0081, "R6 tlb cachable", 0, 1'b0);
        // R6: TLB miss is a no-op
        tlb_miss = 1'b1;
        run_op(mk(5'd6, 1'b0), 32'h4000_0000, 32'h81, 1'b0, 32'h4000_0081, "R6 tlb miss", 0, 1'b0);
        tlb_miss = 1'b0;
        // R6: TLB non-cachable even with mask all ones
        tlb_cachable = 1'b0; region_cache_mask = '1;
        run_op(mk(5'd6, 1'b0), 32'h4000_0000, 32'h81, 1'b0, 32'h4000_0081, "R6 tlb nocache", 0, 1'b0);
        // R7: read denied is a silent no-op
        tlb_cachable = 1'b1; tlb_read_deny = 1'b1;
        run_op(mk(5'd6, 1'b0), 32'h5000_0000, 32'h4, 1'b0, 32'h5000_0004, "R7", 0, 1'b0);
        tlb_read_deny = 1'b0; dtrans_en = 1'b0;
        // R11: record bit set behaves the same
        run_op(mk(5'd3, 1'b1), 32'h1000_0000, 32'h47, 1'b1, 32'h1000_0047, "R11", 1, 1'b0);
        // R10: operation offered during a pending fill is dropped
        run_op(mk(5'd3, 1'b0), 32'h6000_0000, 32'hFF, 1'b1, 32'h6000_00FF, "R10", 4, 1'b1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && done_cnt == 12, "R10 dropped op", done_cnt, 32'd12);
        // R1: wrong primary opcode and wrong extended opcode
        reject_op({6'd30, 5'd2, 5'd3, 5'd7, 10'd262, 1'b0}, "R1 primary");
        reject_op({6'd31, 5'd2, 5'd3, 5'd7, 10'd246, 1'b0}, "R1 extended");
        // R1: valid word accepted after rejections
        run_op(mk(5'd3, 1'b0), 32'h1000_0000, 32'h47, 1'b1, 32'h1000_0047, "R1 accept", 0, 1'b0);

        repeat (3) @(negedge clk);
        chk(dac_cnt == done_cnt, "R8 one strobe per op", dac_cnt, done_cnt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule